// File: doc/BRIEF.md
# Cell FIFO with Interrupt Control

This block sits between a line interface and a host bus and stores fixed-size cells in both directions. Each cell is thirteen 32-bit words: one header word followed by twelve payload words. The receive store and the transmit store each hold 76 cells. On the receive side the line writes words in sequence. A cell is admitted only if the whole cell fits, so the receive store never holds a fragment. A token counter counts the cells that are complete and not yet consumed by the host.

The host reaches the block through a small register port. One address is a data window. A read there pops the oldest receive word, and a write there pushes a transmit word. Other addresses hold the interrupt enables, the write-one-to-clear pending flags, and a level register that shows the receive token count and the transmit word level.

Four events can raise the single interrupt output:
- every completed receive cell;
- a completed receive cell whose header marks the end of a PDU;
- the transmit store dropping below half full;
- the end of a DMA block.

With only the end-of-PDU source enabled, a whole PDU can collect in the receive store before the host is interrupted once.

Top module: `cell_fifo_ctrl`

## Requirements
- R1: The receive store holds 76 cells of 13 words each. Words read from the data window (address 3) come out in the order the line wrote them, and the first word of each cell is its header.
- R2: The token count (address 2, bits [7:0]) rises by one in the cycle the 13th word of an admitted cell is written. It falls by one when the host pops the 13th word of a cell. It is never moved by more than one per cycle.
- R3: When the first word of a cell arrives and fewer than 13 receive words are free, all 13 words of that cell are discarded. Overflow flag bit 4 of the status register (address 1) is then set, and it stays set until it is cleared by writing 1 to it.
- R4: A host read of the data window while the token count is zero pops nothing and leaves the receive store unchanged.
- R5: Status bit 0 is set for every completed receive cell.
- R6: Status bit 1 is set for a completed receive cell only when bit 1 of its header word (the end-of-PDU payload-type bit) is 1.
- R7: Host writes to the data window enter the transmit store and leave on the line port (tx_line_data, valid while tx_line_valid is high) in write order. Writes to a full store (988 words) are ignored. The transmit word level is shown at address 2, bits [31:16].
- R8: Status bit 2 is set when the transmit level goes from 494 or more words to fewer than 494.
- R9: A pulse on dma_done sets status bit 3.
- R10: Control register bits [3:0] (address 0) enable status bits [3:0]. irq is high exactly when an enabled status bit is pending. Writing 1 to a status bit clears it, and an event in the same cycle wins over the clear.
- R11: After reset the token count, all status bits, irq, the enables and tx_line_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line_valid | input | 1 | Line presents a receive word this cycle |
| rx_line_data | input | 32 | Receive word; first of each 13 is the header |
| tx_line_rd | input | 1 | Line takes the transmit head word |
| tx_line_valid | output | 1 | Transmit store not empty |
| tx_line_data | output | 32 | Transmit head word |
| dma_done | input | 1 | End-of-DMA-block pulse |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 level, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops at address 3) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is exercised in three ways:
- A random mix of cell writes and whole-cell reads, with random payloads and a random end-of-PDU bit. This separates correct ordering and token tracking from off-by-one errors in word position.
- Filling the store completely and then offering one more cell. This separates whole-cell discard from partial storage.
- A read strobe against an empty store, followed by a fresh cell. This shows whether a pointer moved.

The transmit path is driven across the 494-word threshold to separate a level-crossing event from a level-state flag. It is then driven into the full state with extra writes, and the drained sequence shows whether any extra word was stored. Interrupt tests switch the enables between the every-cell and end-of-PDU sources, so that the two receive conditions can be told apart.

// File: rtl/cell_fifo_ctrl_pkg.sv
// Package: register addresses and status bit positions shared by the
// cell FIFO controller and its checker.
package cell_fifo_ctrl_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_LEVEL  = 2'd2;
    localparam logic [1:0] ADDR_DATA   = 2'd3;

    localparam int SRC_N      = 5;  // status bits
    localparam int IRQ_SRC_N  = 4;  // status bits that can raise irq
    localparam int ST_RX_CELL = 0;
    localparam int ST_RX_PDU  = 1;
    localparam int ST_TX_HALF = 2;
    localparam int ST_DMA     = 3;
    localparam int ST_RX_OVF  = 4;
endpackage

// File: rtl/cfc_word_fifo.sv
// Module: cfc_word_fifo
// Word-wide circular store with show-ahead head output and an occupancy count.
// Assumes: callers never push when full or pop when empty; depth need not be
// a power of two, so pointers wrap explicitly.
module cfc_word_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 988,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     level
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    // Show-ahead read of the oldest word.
    always_comb head = mem[rptr];
endmodule

// File: rtl/cfc_rx_framer.sv
// Module: cfc_rx_framer
// Tracks word position of line writes and host reads on the receive side,
// admits or discards whole cells, captures the end-of-PDU header bit and
// keeps the complete-cell token count.
// Assumes: the line always delivers whole cells; the host pops only while
// the token count is non-zero.
module cfc_rx_framer #(
    parameter int CELL_W   = 13,
    parameter int CELLS    = 76,
    localparam int DEPTH   = CELLS * CELL_W,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int TOK_W   = $clog2(CELLS + 1),
    localparam int IDX_W   = $clog2(CELL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_valid,
    input  logic             line_flag,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             host_pop,
    output logic             push,
    output logic             cell_done,
    output logic             pdu_end,
    output logic             ovf_evt,
    output logic [TOK_W-1:0] tokens
);
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             drop_q, hdr_end_q;
    logic             first, wr_last, rd_last, room, consumed;
    logic [LVL_W-1:0] free_words;

    // Admission decision and per-word events.
    always_comb begin
        first      = (wr_idx == '0);
        wr_last    = (wr_idx == IDX_W'(CELL_W - 1));
        rd_last    = (rd_idx == IDX_W'(CELL_W - 1));
        free_words = LVL_W'(DEPTH) - rx_level;
        room       = (free_words >= LVL_W'(CELL_W));
        push       = line_valid && (first ? room : !drop_q);
        cell_done  = line_valid && wr_last && !drop_q;
        pdu_end    = cell_done && hdr_end_q;
        ovf_evt    = line_valid && first && !room;
        consumed   = host_pop && rd_last;
    end

    // Line word position, drop state and header flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            drop_q    <= 1'b0;
            hdr_end_q <= 1'b0;
        end else if (line_valid) begin
            wr_idx <= wr_last ? '0 : wr_idx + 1'b1;
            if (first) begin
                drop_q    <= !room;
                hdr_end_q <= line_flag;
            end
        end
    end

    // Host word position within the cell being consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_idx <= '0;
        else if (host_pop) rd_idx <= rd_last ? '0 : rd_idx + 1'b1;
    end

    // Complete-cell token counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tokens <= '0;
        else if (cell_done && !consumed) tokens <= tokens + 1'b1;
        else if (consumed && !cell_done) tokens <= tokens - 1'b1;
    end
endmodule

// File: rtl/cfc_irq_regs.sv
// Module: cfc_irq_regs
// Holds the interrupt enables and the write-one-to-clear pending flags and
// forms the interrupt output.
// Assumes: event inputs are single-cycle pulses; a set beats a clear.
module cfc_irq_regs
    import cell_fifo_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     evt,
    input  logic                 ctrl_wr,
    input  logic [IRQ_SRC_N-1:0] ctrl_wdata,
    input  logic                 clr_wr,
    input  logic [SRC_N-1:0]     clr_bits,
    output logic [IRQ_SRC_N-1:0] ctrl_q,
    output logic [SRC_N-1:0]     status_q,
    output logic                 irq
);
    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_wdata;
    end

    // One sticky pending flag per source.
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)                   status_q[g] <= 1'b0;
            else if (evt[g])              status_q[g] <= 1'b1;
            else if (clr_wr && clr_bits[g]) status_q[g] <= 1'b0;
        end
    end

    // Interrupt request from enabled pending sources.
    always_comb irq = |(status_q[IRQ_SRC_N-1:0] & ctrl_q);
endmodule

// File: rtl/cell_fifo_ctrl.sv
// Module: cell_fifo_ctrl (top)
// Receive and transmit cell stores with a host register port, complete-cell
// token count and interrupt control.
// Assumes: reg_rdata is sampled combinationally; a read strobe at the data
// address pops one receive word when a complete cell is stored.
module cell_fifo_ctrl
    import cell_fifo_ctrl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CELL_W   = 13,
    parameter int CELLS    = 76,
    parameter int FLAG_BIT = 1,
    localparam int DEPTH   = CELLS * CELL_W,
    localparam int HALF    = DEPTH / 2,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int TOK_W   = $clog2(CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line_valid,
    input  logic [DATA_W-1:0] rx_line_data,
    input  logic              tx_line_rd,
    output logic              tx_line_valid,
    output logic [DATA_W-1:0] tx_line_data,
    input  logic              dma_done,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [LVL_W-1:0]     rx_level, tx_level;
    logic [DATA_W-1:0]    rx_head;
    logic [TOK_W-1:0]     rx_tokens;
    logic                 rx_push, rx_pop, cell_done, pdu_end, ovf_evt;
    logic                 tx_push, tx_pop, tx_below, tx_below_q;
    logic [SRC_N-1:0]     evt;
    logic [SRC_N-1:0]     status_q;
    logic [IRQ_SRC_N-1:0] ctrl_q;

    // Host data window strobes and line-side transmit handshake.
    always_comb begin
        rx_pop        = reg_rd && (reg_addr == ADDR_DATA) && (rx_tokens != '0);
        tx_push       = reg_wr && (reg_addr == ADDR_DATA) && (tx_level != LVL_W'(DEPTH));
        tx_pop        = tx_line_rd && (tx_level != '0);
        tx_line_valid = (tx_level != '0);
        tx_below      = (tx_level < LVL_W'(HALF));
    end

    cfc_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_store (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_line_data),
        .pop(rx_pop), .head(rx_head), .level(rx_level)
    );

    cfc_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_store (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata),
        .pop(tx_pop), .head(tx_line_data), .level(tx_level)
    );

    cfc_rx_framer #(.CELL_W(CELL_W), .CELLS(CELLS)) u_framer (
        .clk(clk), .rst_n(rst_n),
        .line_valid(rx_line_valid), .line_flag(rx_line_data[FLAG_BIT]),
        .rx_level(rx_level), .host_pop(rx_pop),
        .push(rx_push), .cell_done(cell_done), .pdu_end(pdu_end),
        .ovf_evt(ovf_evt), .tokens(rx_tokens)
    );

    // Previous below-half state, for the downward crossing event.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_below_q <= 1'b1;
        else        tx_below_q <= tx_below;
    end

    // Event vector in status bit order.
    always_comb begin
        evt             = '0;
        evt[ST_RX_CELL] = cell_done;
        evt[ST_RX_PDU]  = pdu_end;
        evt[ST_TX_HALF] = tx_below && !tx_below_q;
        evt[ST_DMA]     = dma_done;
        evt[ST_RX_OVF]  = ovf_evt;
    end

    cfc_irq_regs u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .ctrl_wr(reg_wr && (reg_addr == ADDR_CTRL)),
        .ctrl_wdata(reg_wdata[IRQ_SRC_N-1:0]),
        .clr_wr(reg_wr && (reg_addr == ADDR_STATUS)),
        .clr_bits(reg_wdata[SRC_N-1:0]),
        .ctrl_q(ctrl_q), .status_q(status_q), .irq(irq)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:   reg_rdata[IRQ_SRC_N-1:0] = ctrl_q;
            ADDR_STATUS: reg_rdata[SRC_N-1:0]     = status_q;
            ADDR_LEVEL: begin
                reg_rdata[TOK_W-1:0]  = rx_tokens;
                reg_rdata[16 +: LVL_W] = tx_level;
            end
            default:     reg_rdata = rx_head;
        endcase
    end
endmodule

// File: rtl/cfc_checker.sv
// Module: cfc_checker
// Temporal properties of the cell FIFO controller, bound into the top.
module cfc_checker #(
    parameter int DEPTH = 988,
    parameter int LVL_W = 10,
    parameter int TOK_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_done,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic             clr_ovf,
    input logic             rx_line_valid,
    input logic             tx_line_rd,
    input logic [4:0]       status,
    input logic [TOK_W-1:0] tokens,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level
);
    AST_DMA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> status[3]);  // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !(reg_wr && reg_addr == 2'd1 && clr_ovf)) |=> status[4]);  // R3

    AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tokens == $past(tokens)) || (tokens == $past(tokens) + 1'b1)
                 || (tokens + 1'b1 == $past(tokens)));  // R2

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd3 && tokens == '0 && !rx_line_valid) |=> $stable(rx_level));  // R4

    AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LVL_W'(DEPTH) && !tx_line_rd) |=> tx_level == LVL_W'(DEPTH));  // R7
endmodule

bind cell_fifo_ctrl cfc_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TOK_W(TOK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_done(dma_done),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .clr_ovf(reg_wdata[4]), .rx_line_valid(rx_line_valid),
    .tx_line_rd(tx_line_rd), .status(status_q), .tokens(rx_tokens),
    .rx_level(rx_level), .tx_level(tx_level)
);

// File: tb/test_cell_fifo_ctrl.sv
module test_cell_fifo_ctrl;
    localparam int CW = 13, CELLS = 76, DEPTH = CELLS * CW, HALF = DEPTH / 2;

    logic        clk = 0, rst_n = 0;
    logic        rx_line_valid = 0, tx_line_rd = 0, dma_done = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [31:0] rx_line_data = 0, reg_wdata = 0;
    logic [1:0]  reg_addr = 0;
    logic        tx_line_valid, irq;
    logic [31:0] tx_line_data, reg_rdata;

    int checks = 0, errors = 0, exp_tok = 0;
    logic [31:0] rxq[$];
    logic [31:0] v;

    always #5 clk = ~clk;

    cell_fifo_ctrl i_cell_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_line_valid(rx_line_valid), .rx_line_data(rx_line_data),
        .tx_line_rd(tx_line_rd), .tx_line_valid(tx_line_valid), .tx_line_data(tx_line_data),
        .dma_done(dma_done), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_pdu_end(logic [31:0] hdr);
        return hdr[1];
    endfunction

    task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 0; #1 d = reg_rdata;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    // Line writes one cell; returns whether the model admits it.
    task automatic line_cell(logic flag, output logic admitted);
        logic [31:0] w;
        admitted = (DEPTH - rxq.size()) >= CW;
        for (int i = 0; i < CW; i++) begin
            w = $urandom;
            if (i == 0) w[1] = flag;
            @(negedge clk); rx_line_valid = 1; rx_line_data = w;
            if (admitted) rxq.push_back(w);
        end
        @(negedge clk); rx_line_valid = 0;
        if (admitted) exp_tok++;
    endtask

    task automatic host_cell(string req);
        int bad = 0;
        logic [31:0] got, exp;
        for (int i = 0; i < CW; i++) begin
            @(negedge clk); reg_addr = 2'd3; reg_rd = 1; #1 got = reg_rdata;
            exp = rxq.pop_front();
            if (got !== exp) begin
                bad++;
                if (bad == 1) $display("FAIL %s: word %0d actual %h expected %h", req, i, got, exp);
            end
        end
        @(negedge clk); reg_rd = 0;
        exp_tok--;
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic check_tok(string req);
        logic [31:0] d;
        rd_reg(2'd2, d);
        check(req, {24'd0, d[7:0]}, exp_tok);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic adm;
        logic [31:0] d;
        int bad;
        v = $urandom(32'd7781);
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        rd_reg(2'd2, d); check("R11 tokens", d, 0);
        rd_reg(2'd1, d); check("R11 status", d, 0);
        rd_reg(2'd0, d); check("R11 ctrl", d, 0);
        check("R11 irq", irq, 0);
        check("R11 tx_valid", tx_line_valid, 0);

        // R5 R6 R10: pdu-end only enable
        wr_reg(2'd0, 32'h2);
        line_cell(0, adm);
        rd_reg(2'd1, d); check("R5 cell status", d[0], 1); check("R6 no pdu", d[1], 0);
        check("R10 irq masked", irq, 0);
        line_cell(1, adm);
        rd_reg(2'd1, d); check("R6 pdu status", d[1], 1);
        check("R10 irq pdu", irq, 1);
        wr_reg(2'd1, 32'h2);
        check("R10 w1c irq", irq, 0);
        rd_reg(2'd1, d); check("R10 w1c keeps bit0", d[1:0], 2'b01);
        wr_reg(2'd0, 32'h1);
        check("R10 irq cell enable", irq, 1);
        check_tok("R2 two cells");
        host_cell("R1 order a");
        host_cell("R1 order b");
        check_tok("R2 drained");

        // R4: empty read ignored
        @(negedge clk); reg_addr = 2'd3; reg_rd = 1;
        @(negedge clk); reg_rd = 0;
        line_cell(0, adm);
        host_cell("R4 no pop on empty");

        // R9 dma done
        wr_reg(2'd1, 32'h1f); wr_reg(2'd0, 32'h8);
        check("R9 irq idle", irq, 0);
        @(negedge clk); dma_done = 1; @(negedge clk); dma_done = 0;
        rd_reg(2'd1, d); check("R9 status", d[3], 1); check("R9 irq", irq, 1);
        wr_reg(2'd1, 32'h8); check("R9 cleared", irq, 0);

        // Random mix, R1 R2 R6
        for (int n = 0; n < 120; n++) begin
            if (exp_tok == 0 || (exp_tok < CELLS && $urandom_range(0, 1) == 1)) begin
                logic f;
                f = $urandom_range(0, 1);
                wr_reg(2'd1, 32'h3);
                line_cell(f, adm);
                rd_reg(2'd1, d); check("R6 random flag", d[1], is_pdu_end({30'd0, f, 1'b0}));
            end else host_cell("R1 random");
            check_tok("R2 random");
        end
        while (exp_tok > 0) host_cell("R1 drain");

        // R3 overflow: fill 76 cells, one more is discarded
        for (int c = 0; c < CELLS; c++) line_cell($urandom_range(0, 1), adm);
        check_tok("R1 full 76");
        wr_reg(2'd1, 32'h1f);
        line_cell(1, adm);
        check("R3 model drop", adm, 0);
        check_tok("R3 tokens unchanged");
        rd_reg(2'd1, d); check("R3 ovf set", d[4], 1); check("R3 no cell event", d[1:0], 0);
        while (exp_tok > 0) host_cell("R3 contents intact");
        rd_reg(2'd1, d); check("R3 ovf sticky", d[4], 1);
        wr_reg(2'd1, 32'h10);
        rd_reg(2'd1, d); check("R3 ovf cleared", d[4], 0);

        // R7 R8 transmit
        wr_reg(2'd0, 32'h4);
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk); reg_addr = 2'd3; reg_wdata = i; reg_wr = 1;
        end
        @(negedge clk); reg_wr = 0;
        wr_reg(2'd1, 32'h1f);
        rd_reg(2'd2, d); check("R7 level half", d[31:16], HALF);
        check("R7 head", tx_line_data, 0); check("R7 valid", tx_line_valid, 1);
        check("R8 no event at half", irq, 0);
        @(negedge clk); tx_line_rd = 1; @(negedge clk); tx_line_rd = 0;
        @(negedge clk);
        rd_reg(2'd1, d); check("R8 below half", d[2], 1); check("R8 irq", irq, 1);
        check("R7 next head", tx_line_data, 1);
        for (int i = HALF; i < DEPTH + 1 + 3; i++) begin
            @(negedge clk); reg_addr = 2'd3; reg_wdata = (i <= DEPTH) ? i : 32'hDEAD_0000; reg_wr = 1;
        end
        @(negedge clk); reg_wr = 0;
        rd_reg(2'd2, d); check("R7 full level", d[31:16], DEPTH);
        bad = 0;
        for (int i = 1; i <= DEPTH; i++) begin
            @(negedge clk); tx_line_rd = 1; #1;
            if (tx_line_data !== i) bad++;
        end
        @(negedge clk); tx_line_rd = 0;
        check("R7 drain order", bad, 0);
        check("R7 empty", tx_line_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule